// File: doc/BRIEF.md
# Windowed Magnitude Comparator Interrupt Unit

This block keeps watch over four converter channels. Each channel delivers 10-bit samples with a strobe that marks a new sample. The host programs two 8-bit limits for each channel, an upper and a lower. These limits define a window. When a fresh sample moves outside that window, a sticky status flag records which side was crossed. An active-low interrupt line stays asserted until software has read the status back.

Only the eight upper bits of a sample take part in the comparison, and both comparisons are strict. A limit left at zero switches off that side of the window. After reset all limits are zero, so the block stays silent until software arms it. Reading the status returns the flags and clears them on the same clock edge. An event that arrives on that same edge is kept, so no crossing can be lost between a read and its clear.

Top module: `win_cmp_irq`

## Requirements
- R1: After reset, every status flag is 0, `irq_n_o` is high and every limit is zero, so no sample value raises a flag until a limit is written.
- R2: Each comparison uses only sample bits [9:2]. Bits [1:0] never influence a flag.
- R3: When a valid sample's upper byte is strictly greater than a non-zero upper limit, the channel's high flag is set on that clock edge.
- R4: When a valid sample's upper byte is strictly less than a non-zero lower limit, the channel's low flag is set on that clock edge.
- R5: A sample whose upper byte equals a limit sets no flag.
- R6: A sample is compared only in a cycle where its channel's strobe `smp_vld_i[ch]` is high. Data presented without the strobe sets no flag.
- R7: The status word has bit 2*ch as channel ch's low flag and bit 2*ch+1 as its high flag. Flags are sticky: once set, a flag stays set until it is cleared by a read.
- R8: `stat_rd_data_o` always shows the current flags. A cycle with `stat_rd_i` high clears every flag at the following edge, except a flag that a new event sets on that same edge, which ends up set.
- R9: `irq_n_o` is low exactly when at least one status flag is set. It falls one edge after the offending sample and rises one edge after the read that empties the status.
- R10: A limit write (`ref_wr_en_i`, with `ref_wr_ch_i` picking the channel, `ref_wr_hi_i`=1 for upper and 0 for lower) takes effect at its clock edge. A sample in the same cycle is compared against the old value, and other channels' limits are unchanged.
- R11: An upper limit of zero disables the high flag, even for the sample 0x3FF. A lower limit of zero disables the low flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_data_i | input | 40 | Four 10-bit samples, channel ch at bits [10*ch+9:10*ch] |
| smp_vld_i | input | 4 | New-sample strobe, one bit per channel |
| ref_wr_en_i | input | 1 | Limit write strobe |
| ref_wr_ch_i | input | 2 | Channel whose limit is written |
| ref_wr_hi_i | input | 1 | 1 selects the upper limit, 0 the lower limit |
| ref_wr_data_i | input | 8 | Limit value |
| stat_rd_i | input | 1 | Status read strobe; clears the flags at the edge |
| stat_rd_data_o | output | 8 | Current status flags |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that the inputs are driven only from synchronous logic, and that `smp_vld_i`, `stat_rd_i` and `ref_wr_en_i` are known (never X) while reset is released. The bench holds every strobe low during reset. It changes inputs only on falling edges and lowers each strobe one cycle after raising it, so every strobe lasts exactly one cycle. The assertions also assume the flags start from the reset state, and the bench keeps reset asserted for several edges before any traffic.

// File: rtl/win_cmp_pkg.sv
// Package: win_cmp_pkg
// Purpose: shared types and helpers for the windowed comparator unit.
// Assumes: the status word pairs flags per channel, low side in the even bit.
package win_cmp_pkg;

    // Which limit of a channel's window is meant
    typedef enum logic {
        SIDE_LOW  = 1'b0,
        SIDE_HIGH = 1'b1
    } win_side_e;

    // Position of a flag in the status word
    function automatic int unsigned flag_pos(input int unsigned ch, input win_side_e side);
        return 2 * ch + ((side == SIDE_HIGH) ? 1 : 0);
    endfunction

endpackage

// File: rtl/win_cmp_ref_bank.sv
// Module: win_cmp_ref_bank
// Purpose: holds the upper and lower limit byte of every channel.
// Assumes: one write per cycle at most; limits reset to zero (disabled).
module win_cmp_ref_bank
    import win_cmp_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int REF_W    = 8,
    parameter int CH_IDX_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [CH_IDX_W-1:0]     wr_ch_i,
    input  logic                    wr_hi_i,
    input  logic [REF_W-1:0]        wr_data_i,
    output logic [NUM_CH*REF_W-1:0] hi_ref_o,
    output logic [NUM_CH*REF_W-1:0] lo_ref_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [REF_W-1:0] hi_q;
        logic [REF_W-1:0] lo_q;
        logic             sel;

        // Decode whether this channel is addressed
        assign sel = wr_en_i && (wr_ch_i == CH_IDX_W'(c));

        // Store a new upper limit when addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q <= '0;
            end else if (sel && (win_side_e'(wr_hi_i) == SIDE_HIGH)) begin
                hi_q <= wr_data_i;
            end
        end

        // Store a new lower limit when addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
            end else if (sel && (win_side_e'(wr_hi_i) == SIDE_LOW)) begin
                lo_q <= wr_data_i;
            end
        end

        assign hi_ref_o[c*REF_W +: REF_W] = hi_q;
        assign lo_ref_o[c*REF_W +: REF_W] = lo_q;
    end

endmodule

// File: rtl/win_cmp_chan.sv
// Module: win_cmp_chan
// Purpose: compares one channel's sample against its window limits.
// Assumes: SAMPLE_W >= REF_W; a zero limit disables that side; strict compare.
module win_cmp_chan #(
    parameter int SAMPLE_W = 10,
    parameter int REF_W    = 8
) (
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic                vld_i,
    input  logic [REF_W-1:0]    hi_ref_i,
    input  logic [REF_W-1:0]    lo_ref_i,
    output logic                hit_hi_o,
    output logic                hit_lo_o
);

    localparam int DROP_W = SAMPLE_W - REF_W;

    logic [REF_W-1:0] top_bits;
    logic             hi_armed;
    logic             lo_armed;

    // Keep only the upper byte of the sample
    assign top_bits = smp_i[SAMPLE_W-1 -: REF_W];

    // A zero limit switches its side off
    always_comb begin
        hi_armed = (hi_ref_i != '0);
        lo_armed = (lo_ref_i != '0);
    end

    // Strict out-of-window detection, qualified by the strobe
    always_comb begin
        hit_hi_o = vld_i && hi_armed && (top_bits > hi_ref_i);
        hit_lo_o = vld_i && lo_armed && (top_bits < lo_ref_i);
    end

    // Discarded low-order bits are intentionally unused
    logic unused_low;
    if (DROP_W > 0) begin : g_drop
        assign unused_low = ^smp_i[DROP_W-1:0];
    end else begin : g_nodrop
        assign unused_low = 1'b0;
    end

endmodule

// File: rtl/win_cmp_status.sv
// Module: win_cmp_status
// Purpose: sticky status flags, clear-on-read, and the active-low request.
// Assumes: hits are one-cycle pulses; a set in the read cycle beats the clear.
module win_cmp_status #(
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] hit_i,
    input  logic              rd_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              irq_n_o
);

    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] flags_d;

    // Next flags: keep unless read, then merge new events
    always_comb begin
        flags_d = (rd_i ? '0 : flags_q) | hit_i;
    end

    // Flag register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    // Request is low while anything is pending
    always_comb begin
        irq_n_o = ~(|flags_q);
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/win_cmp_irq.sv
// Module: win_cmp_irq (top)
// Purpose: four-channel window comparator with sticky flags and interrupt.
// Assumes: synchronous inputs; samples packed channel 0 at the LSBs.
module win_cmp_irq
    import win_cmp_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 10,
    parameter int REF_W    = 8,
    localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int FLAG_W   = 2 * NUM_CH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data_i,
    input  logic [NUM_CH-1:0]          smp_vld_i,
    input  logic                       ref_wr_en_i,
    input  logic [CH_IDX_W-1:0]        ref_wr_ch_i,
    input  logic                       ref_wr_hi_i,
    input  logic [REF_W-1:0]           ref_wr_data_i,
    input  logic                       stat_rd_i,
    output logic [FLAG_W-1:0]          stat_rd_data_o,
    output logic                       irq_n_o
);

    logic [NUM_CH*REF_W-1:0] hi_ref;
    logic [NUM_CH*REF_W-1:0] lo_ref;
    logic [FLAG_W-1:0]       hit;

    win_cmp_ref_bank #(
        .NUM_CH   (NUM_CH),
        .REF_W    (REF_W),
        .CH_IDX_W (CH_IDX_W)
    ) ref_bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (ref_wr_en_i),
        .wr_ch_i   (ref_wr_ch_i),
        .wr_hi_i   (ref_wr_hi_i),
        .wr_data_i (ref_wr_data_i),
        .hi_ref_o  (hi_ref),
        .lo_ref_o  (lo_ref)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        logic h_hi;
        logic h_lo;

        win_cmp_chan #(
            .SAMPLE_W (SAMPLE_W),
            .REF_W    (REF_W)
        ) chan_i (
            .smp_i    (smp_data_i[c*SAMPLE_W +: SAMPLE_W]),
            .vld_i    (smp_vld_i[c]),
            .hi_ref_i (hi_ref[c*REF_W +: REF_W]),
            .lo_ref_i (lo_ref[c*REF_W +: REF_W]),
            .hit_hi_o (h_hi),
            .hit_lo_o (h_lo)
        );

        // Place this channel's hits at their status positions
        assign hit[flag_pos(c, SIDE_LOW)]  = h_lo;
        assign hit[flag_pos(c, SIDE_HIGH)] = h_hi;
    end

    win_cmp_status #(
        .FLAG_W (FLAG_W)
    ) status_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit),
        .rd_i    (stat_rd_i),
        .flags_o (stat_rd_data_o),
        .irq_n_o (irq_n_o)
    );

endmodule

// File: rtl/win_cmp_irq_chk.sv
// Module: win_cmp_irq_chk
// Purpose: protocol and behaviour assertions, bound into win_cmp_irq.
// Assumes: strobes are known whenever reset is released.
module win_cmp_irq_chk #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 10,
    parameter int REF_W    = 8,
    parameter int FLAG_W   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_CH*SAMPLE_W-1:0] smp_data_i,
    input logic [NUM_CH-1:0]          smp_vld_i,
    input logic                       stat_rd_i,
    input logic [FLAG_W-1:0]          stat_rd_data_o,
    input logic                       irq_n_o,
    input logic [NUM_CH*REF_W-1:0]    hi_ref
);

    logic [FLAG_W-1:0] idle_mask;

    // Flags of channels without a strobe this cycle
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            idle_mask[2*c]   = ~smp_vld_i[c];
            idle_mask[2*c+1] = ~smp_vld_i[c];
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (stat_rd_data_o == '0) && irq_n_o);

    // R9
    irq_matches_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == (stat_rd_data_o == '0));

    // R7
    sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stat_rd_i) |-> ((stat_rd_data_o & $past(stat_rd_data_o)) == $past(stat_rd_data_o)));

    // R6
    no_strobe_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_rd_data_o & ~$past(stat_rd_data_o)) & $past(idle_mask)) == '0);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_hi
        // R5
        hi_not_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(smp_data_i[c*SAMPLE_W+SAMPLE_W-1 -: REF_W]) <= $past(hi_ref[c*REF_W +: REF_W]))
            && !$past(stat_rd_data_o[2*c+1]) |-> !stat_rd_data_o[2*c+1]);

        // R11
        hi_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(hi_ref[c*REF_W +: REF_W]) == '0) && !$past(stat_rd_data_o[2*c+1])
            |-> !stat_rd_data_o[2*c+1]);
    end

endmodule

bind win_cmp_irq win_cmp_irq_chk #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .REF_W    (REF_W),
    .FLAG_W   (FLAG_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .smp_data_i     (smp_data_i),
    .smp_vld_i      (smp_vld_i),
    .stat_rd_i      (stat_rd_i),
    .stat_rd_data_o (stat_rd_data_o),
    .irq_n_o        (irq_n_o),
    .hi_ref         (hi_ref)
);

// File: tb/win_cmp_irq_tb_top.sv
module win_cmp_irq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 4;
    localparam int SW         = 10;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NUM_CH*SW-1:0] smp_data = '0;
    logic [NUM_CH-1:0]    smp_vld = '0;
    logic                 wr_en = 1'b0;
    logic [1:0]           wr_ch = '0;
    logic                 wr_hi = 1'b0;
    logic [7:0]           wr_data = '0;
    logic                 rd = 1'b0;
    logic [7:0]           stat;
    logic                 irq_n;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    win_cmp_irq dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .smp_data_i     (smp_data),
        .smp_vld_i      (smp_vld),
        .ref_wr_en_i    (wr_en),
        .ref_wr_ch_i    (wr_ch),
        .ref_wr_hi_i    (wr_hi),
        .ref_wr_data_i  (wr_data),
        .stat_rd_i      (rd),
        .stat_rd_data_o (stat),
        .irq_n_o        (irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle limit write
    task automatic set_ref(input int ch, input bit hi, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_hi = hi; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One-cycle sample; flags are visible on return
    task automatic put_sample(input int ch, input logic [9:0] v);
        @(negedge clk);
        smp_data[ch*SW +: SW] = v; smp_vld[ch] = 1'b1;
        @(negedge clk);
        smp_vld[ch] = 1'b0;
    endtask

    // Read status; returns value seen before the clear
    task automatic read_stat(output logic [7:0] v);
        @(negedge clk);
        v = stat; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status after reset", stat, 8'h00);
        chk("R1 irq after reset", irq_n, 1'b1);
        put_sample(0, 10'h3FF);
        put_sample(1, 10'h000);
        chk("R1 R11 zero limits give no flag", stat, 8'h00);
    endtask

    task automatic t_high();
        logic [7:0] v;
        set_ref(1, 1'b1, 8'h80);
        put_sample(1, 10'h200);
        chk("R5 equal to upper limit", stat, 8'h00);
        put_sample(1, 10'h203);
        chk("R2 low bits ignored", stat, 8'h00);
        put_sample(1, 10'h204);
        chk("R3 high flag ch1 bit3", stat, 8'h08);
        chk("R9 irq low on flag", irq_n, 1'b0);
        read_stat(v);
        chk("R8 read returns flags", v, 8'h08);
        chk("R8 flags cleared by read", stat, 8'h00);
        chk("R9 irq high after clear", irq_n, 1'b1);
    endtask

    task automatic t_low();
        logic [7:0] v;
        set_ref(2, 1'b0, 8'h10);
        put_sample(2, 10'h040);
        chk("R5 equal to lower limit", stat, 8'h00);
        put_sample(2, 10'h03F);
        chk("R4 low flag ch2 bit4", stat, 8'h10);
        read_stat(v);
        chk("R8 clear after low flag", stat, 8'h00);
    endtask

    task automatic t_strobe();
        logic [7:0] v;
        set_ref(3, 1'b1, 8'h01);
        @(negedge clk);
        smp_data[3*SW +: SW] = 10'h3FF;
        repeat (4) @(negedge clk);
        chk("R6 no strobe no flag", stat, 8'h00);
        put_sample(3, 10'h3FF);
        chk("R6 strobe gives high flag ch3 bit7", stat, 8'h80);
        read_stat(v);
    endtask

    task automatic t_read_race();
        logic [7:0] v;
        set_ref(0, 1'b1, 8'h20);
        put_sample(1, 10'h3FC);
        @(negedge clk);
        v = stat;
        rd = 1'b1; smp_data[0 +: SW] = 10'h3FF; smp_vld[0] = 1'b1;
        @(negedge clk);
        rd = 1'b0; smp_vld[0] = 1'b0;
        chk("R8 read value before clear", v, 8'h08);
        chk("R8 same-edge event survives", stat, 8'h02);
        read_stat(v);
    endtask

    task automatic t_write_edge();
        logic [7:0] v;
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'd0; wr_hi = 1'b1; wr_data = 8'hFF;
        smp_data[0 +: SW] = 10'h200; smp_vld[0] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; smp_vld[0] = 1'b0;
        chk("R10 same-cycle sample uses old limit", stat, 8'h02);
        read_stat(v);
        put_sample(0, 10'h3FC);
        chk("R10 new limit applies", stat, 8'h00);
        put_sample(1, 10'h3FF);
        chk("R10 ch1 limit unchanged", stat, 8'h08);
        read_stat(v);
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        put_sample(1, 10'h3FF);
        put_sample(2, 10'h000);
        repeat (5) @(negedge clk);
        chk("R7 flags accumulate and stay", stat, 8'h18);
        chk("R9 irq held low", irq_n, 1'b0);
        read_stat(v);
        chk("R7 read value", v, 8'h18);
    endtask

    task automatic t_zero_off();
        set_ref(3, 1'b1, 8'h00);
        put_sample(3, 10'h3FF);
        put_sample(3, 10'h000);
        chk("R11 zero limits on ch3 disable flags", stat, 8'h00);
        chk("R11 irq stays high", irq_n, 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_high();
        t_low();
        t_strobe();
        t_read_race();
        t_write_edge();
        t_sticky();
        t_zero_off();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule